// File: doc/BRIEF.md
# Satellite Stream Cipher Keystream Generator

This block produces a cipher keystream one bit per clock for a satellite voice and data link. A single start pulse hands it a 64-bit session key, a 19-bit frame number, a burst length and a null-mode flag. The generator first builds a working key: it swaps each adjacent pair of key bytes and folds the frame number into several of the resulting bytes. It feeds that working key serially into four linear feedback shift registers. Then it runs a fixed warm-up of irregular clocking, in which the smallest register alone decides which of the other three advance.

After the warm-up it emits a downlink burst and then an uplink burst of the same length. The uplink burst continues from the register state the downlink burst left behind. Each output bit combines a three-tap majority from each of the three larger registers with one extra tap per register. The surrounding datapath XORs the bits with payload data. A direction flag tells it which burst a bit belongs to, and busy and done tell it when a new frame can be started.

Top module: `sat_keystream_gen`

## Requirements
- R1: Registers A, B, C and D are 19, 22, 23 and 17 bits wide. A step shifts the register left by one, drops the bit that leaves the register, and sets the new bit 0 to the XOR of the old bits selected by the feedback mask. The masks are 0x072000 for A, 0x311000 for B, 0x660000 for C and 0x013100 for D.
- R2: The key input is `key_i`, and input byte j is `key_i[63-8j -: 8]`, so byte 0 is the most significant byte. Working byte j is input byte (j XOR 1). The frame number is then XORed into the working key. Its bits 18:11 go into byte 0 bits 7:0, bits 10:6 into byte 1 bits 7:3, bits 5:4 into byte 3 bits 7:6, and bits 3:0 into byte 6 bits 7:4.
- R3: An accepted start clears all four registers. The next 64 cycles each step every register and then XOR one working-key bit into bit 0 of every register. The bits are taken from working byte 0 to byte 7, most significant bit of each byte first.
- R4: When the last key bit has been loaded, bit 0 of every register is 1.
- R5: In an irregular step, the control bits are bits 15, 6 and 1 of D, and they belong to A, B and C in that order. Let m be the majority value of these three bits. A, B and C each step only when their own control bit equals m. D steps on every irregular step.
- R6: 250 irregular steps follow the key load, and `ks_valid_o` stays low throughout them.
- R7: Each keystream bit comes from one irregular step followed by the output function on the new state. The bit is maj(A1,A6,A15)^A11 ^ maj(B3,B8,B14)^B1 ^ maj(C4,C15,C19)^C0.
- R8: If the start is accepted at clock edge 0, downlink bits appear after edges 315 to 314+n and uplink bits after edges 315+n to 314+2n, where n is the burst length. Each bit is one cycle long and the bits are contiguous. `uplink_o` is 0 for downlink bits and 1 for uplink bits.
- R9: When `null_mode_i` is 1 at start, both bursts keep their timing and every keystream bit is 0.
- R10: After reset, busy, valid and done are low. Busy is high from the edge after an accepted start through the cycle of the last uplink bit. Done is high for exactly that last-bit cycle. A start while busy is high is ignored, and the key and frame inputs then have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted while not busy |
| null_mode_i | input | 1 | Selects the null cipher (all-zero keystream) |
| key_i | input | 64 | Session key, byte 0 in bits 63:56 |
| frame_i | input | 19 | Frame number |
| nbits_i | input | NBITS_W | Length of each burst in bits |
| ks_bit_o | output | 1 | Keystream bit |
| ks_valid_o | output | 1 | Keystream bit is valid |
| uplink_o | output | 1 | 0 = downlink burst, 1 = uplink burst |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse with the last uplink bit |

## Verification
Counting from the edge that samples the start, the load phase takes 64 edges and the warm-up 250. The first keystream bit is therefore visible after edge 315, and bit i after edge 315+i. Busy falls after edge 315+2n, and done coincides with the last bit. The bench drives its inputs and samples its outputs on falling edges. It numbers every rising edge after the start and compares valid, direction, busy, done and the bit itself against those edge numbers in every cycle, so a result one cycle early or late is reported as a mismatch.

// File: rtl/sat_ks_pkg.sv
package sat_ks_pkg;

  localparam int NUM_REGS    = 4;
  localparam int KEY_W       = 64;
  localparam int FN_W        = 19;
  localparam int LOAD_CYCLES = 64;
  localparam int WARM_CYCLES = 250;
  localparam int ST_W        = 32;

  // clock-control taps in the steering register (for A, B, C)
  localparam int CTL_A = 15;
  localparam int CTL_B = 6;
  localparam int CTL_C = 1;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LOAD = 3'd1,
    PH_WARM = 3'd2,
    PH_DL   = 3'd3,
    PH_UL   = 3'd4
  } phase_t;

  function automatic int reg_len(int idx);
    case (idx)
      0:       return 19;
      1:       return 22;
      2:       return 23;
      default: return 17;
    endcase
  endfunction

  function automatic logic [ST_W-1:0] reg_taps(int idx);
    case (idx)
      0:       return 32'h0007_2000;
      1:       return 32'h0031_1000;
      2:       return 32'h0066_0000;
      default: return 32'h0001_3100;
    endcase
  endfunction

  function automatic logic maj3(logic a, logic b, logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // feedback bit: parity of the state bits selected by the mask
  function automatic logic fb_parity(logic [ST_W-1:0] s, logic [ST_W-1:0] m);
    return ^(s & m);
  endfunction

  // per-register step enables during irregular clocking
  function automatic logic [NUM_REGS-1:0] ctl_enables(logic [ST_W-1:0] d, logic irr);
    logic m;
    logic [NUM_REGS-1:0] en;
    m     = maj3(d[CTL_A], d[CTL_B], d[CTL_C]);
    en[0] = irr & (d[CTL_A] == m);
    en[1] = irr & (d[CTL_B] == m);
    en[2] = irr & (d[CTL_C] == m);
    en[3] = irr;
    return en;
  endfunction

  // keystream output combiner
  function automatic logic combine_out(logic [ST_W-1:0] a, logic [ST_W-1:0] b,
                                       logic [ST_W-1:0] c);
    logic pa, pb, pc;
    pa = maj3(a[1], a[6], a[15]) ^ a[11];
    pb = maj3(b[3], b[8], b[14]) ^ b[1];
    pc = maj3(c[4], c[15], c[19]) ^ c[0];
    return pa ^ pb ^ pc;
  endfunction

  // working key: pairwise byte swap, then frame-number fold; byte 0 on top
  function automatic logic [KEY_W-1:0] prep_key(logic [KEY_W-1:0] k, logic [FN_W-1:0] f);
    logic [KEY_W-1:0] w;
    for (int b = 0; b < KEY_W / 8; b++) begin
      w[KEY_W-1-8*b -: 8] = k[KEY_W-1-8*(b ^ 1) -: 8];
    end
    w[63:56] = w[63:56] ^ f[18:11];
    w[55:48] = w[55:48] ^ {f[10:6], 3'b000};
    w[39:32] = w[39:32] ^ {f[5:4], 6'b00_0000};
    w[15:8]  = w[15:8]  ^ {f[3:0], 4'b0000};
    return w;
  endfunction

endpackage

// File: rtl/ks_lfsr.sv
module ks_lfsr
  import sat_ks_pkg::*;
#(
  parameter int              LEN  = 19,
  parameter logic [ST_W-1:0] TAPS = 32'h0007_2000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            load_i,
  input  logic            load_bit_i,
  input  logic            force_i,
  input  logic            step_i,
  output logic [ST_W-1:0] state_o
);

  logic [LEN-1:0] st_q;
  logic [LEN-1:0] shifted;
  logic [LEN-1:0] inj;
  logic           fb;

  assign fb      = fb_parity(state_o, TAPS);
  assign shifted = {st_q[LEN-2:0], fb};
  assign inj     = {{(LEN-1){1'b0}}, load_bit_i};
  assign state_o = {{(ST_W-LEN){1'b0}}, st_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (clr_i) begin
      st_q <= '0;
    end else if (load_i) begin
      st_q <= (shifted ^ inj) | {{(LEN-1){1'b0}}, force_i};
    end else if (step_i) begin
      st_q <= shifted;
    end
  end

endmodule

// File: rtl/ks_clock_ctl.sv
module ks_clock_ctl
  import sat_ks_pkg::*;
(
  input  logic [ST_W-1:0]     steer_i,
  input  logic                irregular_i,
  output logic [NUM_REGS-1:0] step_en_o
);

  assign step_en_o = ctl_enables(steer_i, irregular_i);

endmodule

// File: rtl/ks_sequencer.sv
module ks_sequencer
  import sat_ks_pkg::*;
#(
  parameter int NBITS_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               null_i,
  input  logic [KEY_W-1:0]   key_i,
  input  logic [FN_W-1:0]    frame_i,
  input  logic [NBITS_W-1:0] nbits_i,
  output phase_t             phase_o,
  output logic               clr_o,
  output logic               load_o,
  output logic               load_bit_o,
  output logic               force_o,
  output logic               irregular_o,
  output logic               valid_o,
  output logic               uplink_o,
  output logic               null_o,
  output logic               busy_o,
  output logic               done_o
);

  localparam int CNT_W = ((NBITS_W > 8) ? NBITS_W : 8) + 1;

  phase_t             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   cnt_inc;
  logic [NBITS_W-1:0] n_q;
  logic [KEY_W-1:0]   wk_q;
  logic               null_q;
  logic               valid_q;
  logic               dir_q;
  logic               done_q;

  logic accept;
  logic load_last;
  logic warm_last;
  logic burst_last;

  assign cnt_inc    = cnt_q + CNT_W'(1);
  assign load_last  = (cnt_q == CNT_W'(LOAD_CYCLES - 1));
  assign warm_last  = (cnt_q == CNT_W'(WARM_CYCLES - 1));
  assign burst_last = (cnt_inc == CNT_W'(n_q));

  assign busy_o      = (phase_q != PH_IDLE) || done_q;
  assign accept      = start_i && !busy_o;
  assign clr_o       = accept;
  assign load_o      = (phase_q == PH_LOAD);
  assign load_bit_o  = wk_q[KEY_W-1];
  assign force_o     = load_o && load_last;
  assign irregular_o = (phase_q == PH_WARM) || (phase_q == PH_DL) || (phase_q == PH_UL);
  assign phase_o     = phase_q;
  assign valid_o     = valid_q;
  assign uplink_o    = dir_q;
  assign null_o      = null_q;
  assign done_o      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      n_q     <= '0;
      wk_q    <= '0;
      null_q  <= 1'b0;
      valid_q <= 1'b0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            phase_q <= PH_LOAD;
            cnt_q   <= '0;
            n_q     <= nbits_i;
            null_q  <= null_i;
            wk_q    <= prep_key(key_i, frame_i);
          end
        end
        PH_LOAD: begin
          wk_q <= {wk_q[KEY_W-2:0], 1'b0};
          if (load_last) begin
            phase_q <= PH_WARM;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_inc;
          end
        end
        PH_WARM: begin
          if (warm_last) begin
            cnt_q <= '0;
            if (n_q == '0) begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end else begin
              phase_q <= PH_DL;
            end
          end else begin
            cnt_q <= cnt_inc;
          end
        end
        PH_DL: begin
          valid_q <= 1'b1;
          dir_q   <= 1'b0;
          if (burst_last) begin
            phase_q <= PH_UL;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_inc;
          end
        end
        PH_UL: begin
          valid_q <= 1'b1;
          dir_q   <= 1'b1;
          if (burst_last) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_inc;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R10
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && phase_q == PH_WARM) |=> (phase_q != PH_LOAD)); // R10
  AST_NO_VALID_BEFORE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE || phase_q == PH_LOAD || phase_q == PH_WARM) |=> !valid_q); // R6

endmodule

// File: rtl/sat_keystream_gen.sv
module sat_keystream_gen
  import sat_ks_pkg::*;
#(
  parameter int NBITS_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               null_mode_i,
  input  logic [63:0]        key_i,
  input  logic [18:0]        frame_i,
  input  logic [NBITS_W-1:0] nbits_i,
  output logic               ks_bit_o,
  output logic               ks_valid_o,
  output logic               uplink_o,
  output logic               busy_o,
  output logic               done_o
);

  phase_t              phase;
  logic                clr;
  logic                load;
  logic                load_bit;
  logic                force_one;
  logic                irregular;
  logic                valid;
  logic                null_sel;
  logic [NUM_REGS-1:0] step_en;
  logic [ST_W-1:0]     reg_st [NUM_REGS];
  logic                raw_bit;

  ks_sequencer #(.NBITS_W(NBITS_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .null_i      (null_mode_i),
    .key_i       (key_i),
    .frame_i     (frame_i),
    .nbits_i     (nbits_i),
    .phase_o     (phase),
    .clr_o       (clr),
    .load_o      (load),
    .load_bit_o  (load_bit),
    .force_o     (force_one),
    .irregular_o (irregular),
    .valid_o     (valid),
    .uplink_o    (uplink_o),
    .null_o      (null_sel),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  ks_clock_ctl u_ctl (
    .steer_i     (reg_st[NUM_REGS-1]),
    .irregular_i (irregular),
    .step_en_o   (step_en)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam int              G_LEN  = reg_len(g);
    localparam logic [ST_W-1:0] G_TAPS = reg_taps(g);

    ks_lfsr #(.LEN(G_LEN), .TAPS(G_TAPS)) u_lfsr (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (clr),
      .load_i     (load),
      .load_bit_i (load_bit),
      .force_i    (force_one),
      .step_i     (step_en[g]),
      .state_o    (reg_st[g])
    );

    AST_HOLD_UNSTEPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (irregular && !step_en[g] && !clr) |=> $stable(reg_st[g])); // R5
  end

  assign raw_bit    = combine_out(reg_st[0], reg_st[1], reg_st[2]);
  assign ks_valid_o = valid;
  assign ks_bit_o   = valid & ~null_sel & raw_bit;

  AST_LOAD_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase == PH_LOAD) |-> ((reg_st[0] | reg_st[1] | reg_st[2] | reg_st[3]) == '0)); // R3
  AST_FORCED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase == PH_WARM) |-> (reg_st[0][0] && reg_st[1][0] && reg_st[2][0] && reg_st[3][0])); // R4
  AST_NULL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ks_valid_o && null_sel) |-> !ks_bit_o); // R9
  AST_VALID_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ks_valid_o |-> busy_o); // R10
  AST_STEER_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    irregular |-> (step_en[NUM_REGS-1] && $countones(step_en[NUM_REGS-2:0]) >= 2)); // R5

endmodule

// File: tb/sat_keystream_gen_tb_top.sv
module sat_keystream_gen_tb_top;

  localparam int NBW  = 12;
  localparam int MAXN = 64;
  localparam int FIRST_EDGE = 315;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           nullm = 1'b0;
  logic [63:0]    key = '0;
  logic [18:0]    fn = '0;
  logic [NBW-1:0] nb = '0;
  logic           ks_bit, ks_valid, uplink, busy, done;

  int  compared = 0;
  int  mismatched = 0;
  bit  finished = 1'b0;
  bit  exp_bits [0:2*MAXN-1];

  always #10 clk = ~clk;

  sat_keystream_gen #(.NBITS_W(NBW)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .null_mode_i (nullm),
    .key_i       (key),
    .frame_i     (fn),
    .nbits_i     (nb),
    .ks_bit_o    (ks_bit),
    .ks_valid_o  (ks_valid),
    .uplink_o    (uplink),
    .busy_o      (busy),
    .done_o      (done)
  );

  task automatic chk(input string req, input int act, input int expv);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // ---------------- behavioural model ----------------
  // R1: feedback from explicit tap positions, then truncate to length
  function automatic logic [31:0] m_step(logic [31:0] s, int len,
                                         int t0, int t1, int t2, int t3);
    logic [31:0] ns;
    ns = {s[30:0], s[t0] ^ s[t1] ^ s[t2] ^ s[t3]};
    for (int b = len; b < 32; b++) ns[b] = 1'b0;
    return ns;
  endfunction

  task automatic m_step_all(inout logic [31:0] a, inout logic [31:0] b,
                            inout logic [31:0] c, inout logic [31:0] d);
    a = m_step(a, 19, 13, 16, 17, 18);
    b = m_step(b, 22, 12, 16, 20, 21);
    c = m_step(c, 23, 17, 18, 21, 22);
    d = m_step(d, 17, 8, 12, 13, 16);
  endtask

  // R5: vote among D bits 15, 6, 1
  task automatic m_irregular(inout logic [31:0] a, inout logic [31:0] b,
                             inout logic [31:0] c, inout logic [31:0] d);
    int  votes;
    bit  mv;
    votes = int'(d[15]) + int'(d[6]) + int'(d[1]);
    mv = (votes >= 2);
    if (d[15] == mv) a = m_step(a, 19, 13, 16, 17, 18);
    if (d[6]  == mv) b = m_step(b, 22, 12, 16, 20, 21);
    if (d[1]  == mv) c = m_step(c, 23, 17, 18, 21, 22);
    d = m_step(d, 17, 8, 12, 13, 16);
  endtask

  function automatic bit m_maj(bit x, bit y, bit z);
    return (int'(x) + int'(y) + int'(z)) > 1;
  endfunction

  // R7
  function automatic bit m_out(logic [31:0] a, logic [31:0] b, logic [31:0] c);
    return (m_maj(a[1], a[6], a[15]) ^ a[11]) ^
           (m_maj(b[3], b[8], b[14]) ^ b[1]) ^
           (m_maj(c[4], c[15], c[19]) ^ c[0]);
  endfunction

  task automatic model_run(input logic [63:0] k, input logic [18:0] f,
                           input int n, input bit nm);
    logic [7:0]  kb [8];
    logic [7:0]  lk [8];
    logic [31:0] a, b, c, d;
    bit          kbit;
    // R2: byte 0 is key[63:56]; swap pairs; fold frame number
    for (int i = 0; i < 8; i++) kb[i] = k[63-8*i -: 8];
    for (int i = 0; i < 8; i++) lk[i] = kb[i ^ 1];
    lk[6] = lk[6] ^ {f[3:0], 4'h0};
    lk[3] = lk[3] ^ {f[5:4], 6'h00};
    lk[1] = lk[1] ^ {f[10:6], 3'h0};
    lk[0] = lk[0] ^ {f[18:16], f[15:11]};
    a = '0; b = '0; c = '0; d = '0;
    // R3: step then inject, byte 0 first, MSB first
    for (int i = 0; i < 64; i++) begin
      kbit = lk[i / 8][7 - (i % 8)];
      m_step_all(a, b, c, d);
      a[0] = a[0] ^ kbit; b[0] = b[0] ^ kbit;
      c[0] = c[0] ^ kbit; d[0] = d[0] ^ kbit;
    end
    // R4
    a[0] = 1'b1; b[0] = 1'b1; c[0] = 1'b1; d[0] = 1'b1;
    // R6
    for (int i = 0; i < 250; i++) m_irregular(a, b, c, d);
    // R8: downlink then uplink from the same state
    for (int i = 0; i < 2 * n; i++) begin
      m_irregular(a, b, c, d);
      exp_bits[i] = nm ? 1'b0 : m_out(a, b, c);
    end
  endtask

  // ---------------- run driver ----------------
  task automatic run_case(input string tag, input logic [63:0] k, input logic [18:0] f,
                          input int n, input bit nm, input bit poke);
    int last;
    int idx;
    bit vexp;
    model_run(k, f, n, nm);
    last = FIRST_EDGE - 1 + 2 * n;
    @(negedge clk);
    key = k; fn = f; nb = NBW'(n); nullm = nm; start = 1'b1;
    @(negedge clk);   // edge 0 has sampled the start
    start = 1'b0;
    for (int e = 1; e <= last + 2; e++) begin
      @(negedge clk);
      vexp = (e >= FIRST_EDGE) && (e <= last);
      chk({tag, " R6/R8 valid"}, int'(ks_valid), int'(vexp));
      chk({tag, " R10 busy"}, int'(busy), int'(e <= last));
      chk({tag, " R10 done"}, int'(done), int'(e == last));
      if (vexp && ks_valid) begin
        idx = e - FIRST_EDGE;
        chk({tag, " R7 bit"}, int'(ks_bit), int'(exp_bits[idx]));
        chk({tag, " R8 uplink"}, int'(uplink), int'(idx >= n));
      end
      if (poke && e == 100) begin
        start = 1'b1; key = ~k; fn = ~f; nullm = ~nm;  // R10 ignored while busy
      end
      if (poke && e == 101) begin
        start = 1'b0; key = k; fn = f; nullm = nm;
      end
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("reset R10 busy", int'(busy), 0);
    chk("reset R10 valid", int'(ks_valid), 0);
    chk("reset R10 done", int'(done), 0);
  endtask

  task automatic t_zero_key;       // R3 R4 R7 with an all-zero key
    run_case("zero_key", 64'h0, 19'h0, 8, 1'b0, 1'b0);
  endtask

  task automatic t_frame_fields;   // R2 every frame-number field set
    run_case("frame_fields", 64'h0123_4567_89AB_CDEF, 19'h7FFFF, 24, 1'b0, 1'b0);
  endtask

  task automatic t_single_bit;     // R8 burst length 1
    run_case("single_bit", 64'hFEDC_BA98_7654_3210, 19'h12345, 1, 1'b0, 1'b0);
  endtask

  task automatic t_null_mode;      // R9
    run_case("null_mode", 64'hDEAD_BEEF_0BAD_F00D, 19'h2A5C3, 16, 1'b1, 1'b0);
  endtask

  task automatic t_start_while_busy; // R10
    run_case("busy_start", 64'h1357_9BDF_2468_ACE0, 19'h00F0F, 12, 1'b0, 1'b1);
  endtask

  task automatic t_long_burst;     // R1 R5 long irregular run
    run_case("long_burst", 64'hA5A5_0F0F_C3C3_7E7E, 19'h5A5A5, MAXN, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_zero_key();
    t_frame_fields();
    t_single_bit();
    t_null_mode();
    t_start_while_busy();
    t_long_burst();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule